// File: doc/BRIEF.md
# Block-Scaled FP4 Dot-Product Engine

This engine takes a stream of paired 4-bit floating-point operands, one activation and one weight per cycle, and forms their dot product over a block of `BLOCK` elements. It has no hardware mantissa multiplier. Each element product is split into three paths. The sign comes from an exclusive-OR of the operand signs. The exponent comes from a small integer add. The significand product is read from a 16-entry table, indexed by the operands' leading-bit flags and mantissa bits. The products are widened into an exact signed fixed-point accumulator with two fraction bits.

When the last element of a block arrives, the accumulated sum is scaled by the block's 8-bit float scale. The scale uses 1 sign bit, 4 exponent bits with bias 7 and 3 mantissa bits. Its significand is applied with a shift-and-add network. Its exponent is reported as a separate signed output rather than applied as a shift. A 32-bit per-tensor scale is captured with the block and handed out unchanged beside the result, so that a later stage can apply it.

A user marks the first element of each block. The engine latches both scales on that element. It accepts further elements whenever `elem_valid` is high, including after idle gaps. It pulses `done` in the cycle after the final element, and the outputs then hold until the next block completes.

Top module: `fp4_blockdot`

## Requirements
- R1: A product's sign is the exclusive-OR of the two operand sign bits (bit 3 of each code). An operand whose low three bits are 000 is a zero and yields a zero product, whatever either sign bit is.
- R2: An operand code uses bit 3 as sign, bits 2:1 as exponent e and bit 0 as mantissa m. Its magnitude is m/2 when e = 0, and (1 + m/2)·2^(e−1) otherwise. Every element product equals the exact product of these values.
- R3: The block sum is exact and does not overflow for any `BLOCK` operand pairs, including every element at magnitude 6 × 6 = 36 with either sign.
- R4: A valid element with `elem_first` high starts a new block and latches `blk_scale` and `tns_scale`. Scale input values on later elements are ignored. `done` is high for exactly the one cycle after the `BLOCK`-th accepted element. Cycles with `elem_valid` low between elements are skipped.
- R5: A valid element without `elem_first` while no block is open is ignored. It causes no `done` pulse and leaves the outputs unchanged.
- R6: A first-marked element that arrives while a block is open discards the partial sum and count and starts a fresh block.
- R7: The block scale uses bit 7 as sign, bits 6:3 as exponent s and bits 2:0 as mantissa f. Its significand is (8·h + f)/8, where h = 1 when s ≠ 0 and h = 0 otherwise. When `done` pulses, `dot_mant` equals (block sum in quarters) × (8·h + f), negated when the scale sign is set, and `dot_exp` equals max(s, 1) − 7. The result value is `dot_mant`·2^(`dot_exp` − 5).
- R8: When `done` pulses, `tns_out` equals the `tns_scale` value latched on that block's first element.
- R9: Reset clears `done`, `dot_mant`, `dot_exp` and `tns_out` to zero. Between `done` pulses, all three data outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| elem_valid | input | 1 | An operand pair is present this cycle |
| elem_first | input | 1 | This element opens a block |
| act_code | input | 4 | Activation, 4-bit float code |
| wgt_code | input | 4 | Weight, 4-bit float code |
| blk_scale | input | 8 | Per-block 8-bit float scale, sampled with the first element |
| tns_scale | input | 32 | Per-tensor 32-bit scale, sampled with the first element |
| done | output | 1 | One-cycle pulse: block result valid |
| dot_mant | output | ACC_W+5 (18) | Signed scaled sum, 5 fraction bits |
| dot_exp | output | 5 | Signed exponent of the result |
| tns_out | output | 32 | Tensor scale of the finished block |

## Verification
The assertions assume that `elem_valid` and `elem_first` are driven to known values in every cycle after reset. They also assume that the block scale never needs a NaN meaning, because the all-ones exponent and mantissa code is treated as an ordinary magnitude. The stimulus keeps to these assumptions: control inputs are driven low whenever they are not in use, and every scale byte, including the all-ones code, is checked against the plain arithmetic formula. The bench drives scale inputs to inverted values on non-first elements. Any sampling of the scales after the opening element therefore shows up as a wrong result, and the assertion on the passed-through tensor scale relies on this.

// File: rtl/fp4dot_pkg.sv
// Package fp4dot_pkg
// Shared operand layouts, fixed format widths and the constant function
// that fills the significand-product table. Assumes 4-bit operands with a
// 2-bit exponent and a 1-bit mantissa, and an 8-bit scale with 4/3 split.
package fp4dot_pkg;

    localparam int CODE_W  = 4;    // operand code width
    localparam int SCL_W   = 8;    // block scale width
    localparam int TNS_W   = 32;   // tensor scale width
    localparam int SIG_W   = 4;    // scale significand bits (hidden + 3)
    localparam int EXP_W   = 5;    // signed result exponent width
    localparam int PROD_W  = 9;    // signed product width in quarters (|p| <= 144)
    localparam int PMAX_Q  = 144;  // largest product magnitude in quarters
    localparam int LUT_N   = 16;   // table entries
    localparam int SC_BIAS = 7;    // scale exponent bias

    // 4-bit operand: sign, exponent, mantissa
    typedef struct packed {
        logic       sgn;
        logic [1:0] ex;
        logic       man;
    } fp4_t;

    // 8-bit block scale: sign, exponent, mantissa
    typedef struct packed {
        logic       sgn;
        logic [3:0] ex;
        logic [2:0] man;
    } sc8_t;

    // Table entry for index {hid_a, man_a, hid_b, man_b}: product of the
    // two 2-bit significands in half units, built by repeated addition.
    function automatic logic [3:0] sig_prod(input int idx);
        int sa;
        int sb;
        int acc;
        sa  = ((idx >> 3) & 1) * 2 + ((idx >> 2) & 1);
        sb  = ((idx >> 1) & 1) * 2 + (idx & 1);
        acc = 0;
        for (int k = 0; k < 3; k++) begin
            if (k < sb) acc = acc + sa;
        end
        return 4'(acc);
    endfunction

endpackage

// File: rtl/fp4_elem_mul.sv
// Module fp4_elem_mul
// Forms one operand-pair product without a multiplier: sign by XOR,
// exponent by integer add, significand product from a 16-entry table.
// Output is a signed fixed-point value in quarter units. Purely combinational.
// Assumes operand codes follow fp4dot_pkg::fp4_t.
module fp4_elem_mul
    import fp4dot_pkg::*;
#(
    parameter int P_W = PROD_W
) (
    input  fp4_t                  act,
    input  fp4_t                  wgt,
    output logic signed [P_W-1:0] prod_q
);

    localparam int MAG_W = P_W - 1;

    logic [3:0]       lut [LUT_N];
    logic             hid_a;
    logic             hid_b;
    logic [1:0]       ee_a;
    logic [1:0]       ee_b;
    logic [2:0]       e_sum;
    logic [3:0]       lut_idx;
    logic [MAG_W-1:0] mag;
    logic             neg;

    // Table contents are constants computed at elaboration
    for (genvar g = 0; g < LUT_N; g++) begin : g_lut
        assign lut[g] = sig_prod(g);
    end

    // Decode hidden bits and unbiased exponents of both operands
    always_comb begin
        hid_a = |act.ex;
        hid_b = |wgt.ex;
        ee_a  = hid_a ? (act.ex - 2'd1) : 2'd0;
        ee_b  = hid_b ? (wgt.ex - 2'd1) : 2'd0;
    end

    // Exponent path, table lookup, alignment and sign application
    always_comb begin
        e_sum   = {1'b0, ee_a} + {1'b0, ee_b};
        lut_idx = {hid_a, act.man, hid_b, wgt.man};
        mag     = MAG_W'(lut[lut_idx]) << e_sum;
        neg     = act.sgn ^ wgt.sgn;
        prod_q  = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

endmodule

// File: rtl/blk_accum.sv
// Module blk_accum
// Block framing and accumulation. Opens a block on a first-marked valid
// element, counts accepted elements, keeps the running sum and the latched
// scales, and flags the element that closes the block. The next-sum value
// is exported so the closing element's result can be registered at once.
// Assumes prod_q already in quarter units; accumulator wide enough for BLOCK.
module blk_accum
    import fp4dot_pkg::*;
#(
    parameter int BLOCK = 16,
    parameter int ACC_W = 13,
    parameter int P_W   = PROD_W,
    parameter int CNT_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    elem_valid,
    input  logic                    elem_first,
    input  logic signed [P_W-1:0]   prod_q,
    input  logic [SCL_W-1:0]        blk_scale,
    input  logic [TNS_W-1:0]        tns_scale,
    output logic signed [ACC_W-1:0] acc_nxt,
    output logic                    last,
    output logic [SCL_W-1:0]        scale_sel,
    output logic [TNS_W-1:0]        tns_sel
);

    logic                    busy_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [CNT_W-1:0]        cnt_nxt;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] prod_ext;
    logic signed [ACC_W-1:0] base;
    logic [SCL_W-1:0]        sc_q;
    logic [TNS_W-1:0]        ts_q;
    logic                    step;

    // Next-state arithmetic for the sum, count and closing flag
    always_comb begin
        step      = elem_valid & (elem_first | busy_q);
        prod_ext  = {{(ACC_W-P_W){prod_q[P_W-1]}}, prod_q};
        base      = elem_first ? '0 : acc_q;
        acc_nxt   = base + prod_ext;
        cnt_nxt   = elem_first ? CNT_W'(1) : cnt_q + CNT_W'(1);
        last      = step & (cnt_nxt == CNT_W'(BLOCK));
        scale_sel = elem_first ? blk_scale : sc_q;
        tns_sel   = elem_first ? tns_scale : ts_q;
    end

    // Block state registers, updated only on accepted elements
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            acc_q  <= '0;
            sc_q   <= '0;
            ts_q   <= '0;
        end else if (step) begin
            acc_q  <= acc_nxt;
            cnt_q  <= last ? '0 : cnt_nxt;
            busy_q <= ~last;
            if (elem_first) begin
                sc_q <= blk_scale;
                ts_q <= tns_scale;
            end
        end
    end

endmodule

// File: rtl/sc8_scaler.sv
// Module sc8_scaler
// Applies the block scale's significand to the block sum by shift-and-add
// over its four significand bits and applies its sign; the scale exponent
// is reported unbiased rather than applied. Combinational. Assumes the
// all-ones scale code is an ordinary value (no NaN handling).
module sc8_scaler
    import fp4dot_pkg::*;
#(
    parameter int ACC_W  = 13,
    parameter int MANT_W = 18
) (
    input  logic signed [ACC_W-1:0]  acc,
    input  sc8_t                     scale,
    output logic signed [MANT_W-1:0] mant,
    output logic signed [EXP_W-1:0]  exp_u
);

    logic [SIG_W-1:0]         sig;
    logic signed [MANT_W-1:0] acc_x;
    logic signed [MANT_W-1:0] part [SIG_W];
    logic signed [MANT_W-1:0] mag;
    logic [3:0]               eff_ex;

    // Significand with hidden bit, widened sum
    always_comb begin
        sig   = {|scale.ex, scale.man};
        acc_x = {{(MANT_W-ACC_W){acc[ACC_W-1]}}, acc};
    end

    // One shifted partial term per significand bit
    for (genvar b = 0; b < SIG_W; b++) begin : g_part
        assign part[b] = sig[b] ? (acc_x <<< b) : '0;
    end

    // Sum the partial terms and apply the scale sign
    always_comb begin
        mag = '0;
        for (int b = 0; b < SIG_W; b++) begin
            mag = mag + part[b];
        end
        mant = scale.sgn ? -mag : mag;
    end

    // Unbiased exponent, subnormal scales use exponent 1
    always_comb begin
        eff_ex = (scale.ex == 4'd0) ? 4'd1 : scale.ex;
        exp_u  = $signed({1'b0, eff_ex}) - EXP_W'(SC_BIAS);
    end

endmodule

// File: rtl/fp4_blockdot.sv
// Module fp4_blockdot
// Top level of the block-scaled FP4 dot-product engine. Streams operand
// pairs through the table-based element multiplier into the block
// accumulator, scales the closing sum by the block scale, and registers
// the result with a one-cycle done pulse. Assumes one element per cycle
// at most and BLOCK >= 1.
module fp4_blockdot
    import fp4dot_pkg::*;
#(
    parameter  int BLOCK  = 16,
    localparam int ACC_W  = $clog2(BLOCK * PMAX_Q + 1) + 1,
    localparam int MANT_W = ACC_W + 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     elem_valid,
    input  logic                     elem_first,
    input  logic [CODE_W-1:0]        act_code,
    input  logic [CODE_W-1:0]        wgt_code,
    input  logic [SCL_W-1:0]         blk_scale,
    input  logic [TNS_W-1:0]         tns_scale,
    output logic                     done,
    output logic signed [MANT_W-1:0] dot_mant,
    output logic signed [EXP_W-1:0]  dot_exp,
    output logic [TNS_W-1:0]         tns_out
);

    localparam int CNT_W = $clog2(BLOCK + 1);

    logic signed [PROD_W-1:0] prod_q;
    logic signed [ACC_W-1:0]  acc_nxt;
    logic                     last;
    logic [SCL_W-1:0]         scale_sel;
    logic [TNS_W-1:0]         tns_sel;
    logic signed [MANT_W-1:0] sc_mant;
    logic signed [EXP_W-1:0]  sc_exp;

    fp4_elem_mul #(
        .P_W (PROD_W)
    ) mul_i (
        .act    (fp4_t'(act_code)),
        .wgt    (fp4_t'(wgt_code)),
        .prod_q (prod_q)
    );

    blk_accum #(
        .BLOCK (BLOCK),
        .ACC_W (ACC_W),
        .P_W   (PROD_W),
        .CNT_W (CNT_W)
    ) acc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .elem_valid (elem_valid),
        .elem_first (elem_first),
        .prod_q     (prod_q),
        .blk_scale  (blk_scale),
        .tns_scale  (tns_scale),
        .acc_nxt    (acc_nxt),
        .last       (last),
        .scale_sel  (scale_sel),
        .tns_sel    (tns_sel)
    );

    sc8_scaler #(
        .ACC_W  (ACC_W),
        .MANT_W (MANT_W)
    ) scl_i (
        .acc   (acc_nxt),
        .scale (sc8_t'(scale_sel)),
        .mant  (sc_mant),
        .exp_u (sc_exp)
    );

    // Output register: pulse done and capture the result on the closing element
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            dot_mant <= '0;
            dot_exp  <= '0;
            tns_out  <= '0;
        end else begin
            done <= last;
            if (last) begin
                dot_mant <= sc_mant;
                dot_exp  <= sc_exp;
                tns_out  <= tns_sel;
            end
        end
    end

endmodule

// File: rtl/fp4_blockdot_chk.sv
// Module fp4_blockdot_chk
// Checker bound to fp4_blockdot. Keeps its own count of accepted elements
// and its own copy of the tensor scale seen on first-marked elements, and
// relates them to the outputs. Assumes control inputs known after reset.
module fp4_blockdot_chk
    import fp4dot_pkg::*;
#(
    parameter int BLOCK  = 16,
    parameter int MANT_W = 18
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     elem_valid,
    input logic                     elem_first,
    input logic [TNS_W-1:0]         tns_scale,
    input logic                     done,
    input logic signed [MANT_W-1:0] dot_mant,
    input logic signed [EXP_W-1:0]  dot_exp,
    input logic [TNS_W-1:0]         tns_out
);

    localparam int  CW      = $clog2(BLOCK + 1);
    localparam longint MAXM = longint'(BLOCK) * PMAX_Q * 15;

    logic [CW-1:0]      seen_cnt;
    logic [TNS_W-1:0]   seen_ts;
    logic [MANT_W-1:0]  abs_mant;

    // Observed element count since the last first-marked element
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_cnt <= '0;
            seen_ts  <= '0;
        end else if (elem_valid && elem_first) begin
            seen_cnt <= CW'(1);
            seen_ts  <= tns_scale;
        end else if (elem_valid && seen_cnt != '0 && seen_cnt != CW'(BLOCK)) begin
            seen_cnt <= seen_cnt + CW'(1);
        end
    end

    // Magnitude of the result for the range check
    always_comb abs_mant = dot_mant[MANT_W-1] ? -dot_mant : dot_mant;

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> seen_cnt == CW'(BLOCK)) else $error("done without full block"); // R4

    AST_DONE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(elem_valid)) else $error("done without element"); // R5

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(dot_mant) && $stable(dot_exp) && $stable(tns_out)))
        else $error("outputs moved without done"); // R9

    AST_TNS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> tns_out == seen_ts) else $error("tensor scale altered"); // R8

    AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dot_exp >= -5'sd6 && dot_exp <= 5'sd8)) else $error("exponent range"); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> longint'(abs_mant) <= MAXM) else $error("result magnitude bound"); // R3

endmodule

bind fp4_blockdot fp4_blockdot_chk #(
    .BLOCK  (BLOCK),
    .MANT_W (MANT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .elem_valid (elem_valid),
    .elem_first (elem_first),
    .tns_scale  (tns_scale),
    .done       (done),
    .dot_mant   (dot_mant),
    .dot_exp    (dot_exp),
    .tns_out    (tns_out)
);

// File: tb/fp4_blockdot_tb_top.sv
`timescale 1ns/1ps
module fp4_blockdot_tb_top;

    localparam int BLOCK  = 16;
    localparam int ACC_W  = $clog2(BLOCK * 144 + 1) + 1;
    localparam int MANT_W = ACC_W + 5;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     elem_valid = 1'b0;
    logic                     elem_first = 1'b0;
    logic [3:0]               act_code = '0;
    logic [3:0]               wgt_code = '0;
    logic [7:0]               blk_scale = '0;
    logic [31:0]              tns_scale = '0;
    logic                     done;
    logic signed [MANT_W-1:0] dot_mant;
    logic signed [4:0]        dot_exp;
    logic [31:0]              tns_out;

    int     n_cmp = 0;
    int     n_bad = 0;
    int     cyc   = 0;
    logic [3:0] ba [BLOCK];
    logic [3:0] bw [BLOCK];

    always #2 clk = ~clk;

    fp4_blockdot #(.BLOCK(BLOCK)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .elem_valid (elem_valid),
        .elem_first (elem_first),
        .act_code   (act_code),
        .wgt_code   (wgt_code),
        .blk_scale  (blk_scale),
        .tns_scale  (tns_scale),
        .done       (done),
        .dot_mant   (dot_mant),
        .dot_exp    (dot_exp),
        .tns_out    (tns_out)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(string tag, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Operand magnitude in half units (R2)
    function automatic longint halves(logic [3:0] c);
        if (c[2:1] == 2'd0) return longint'(c[0]);
        return longint'(2 + c[0]) <<< (c[2:1] - 1);
    endfunction

    // Signed product in quarter units (R1, R2)
    function automatic longint prod_q(logic [3:0] a, logic [3:0] w);
        longint p;
        p = halves(a) * halves(w);
        return (a[3] ^ w[3]) ? -p : p;
    endfunction

    function automatic longint exp_mant(longint s, logic [7:0] bs);
        longint sig;
        longint r;
        sig = ((bs[6:3] != 0) ? 8 : 0) + bs[2:0];
        r   = s * sig;
        return bs[7] ? -r : r;
    endfunction

    function automatic longint exp_exp(logic [7:0] bs);
        return ((bs[6:3] == 0) ? 1 : longint'(bs[6:3])) - 7;
    endfunction

    // Stream the block in ba/bw; scale inputs are inverted after the first element
    task automatic run_block(string tag, logic [7:0] bs, logic [31:0] ts, bit gaps);
        longint s;
        s = 0;
        for (int i = 0; i < BLOCK; i++) begin
            @(negedge clk);
            if (i > 0) check({tag, " R4 no early done"}, done, 0);
            elem_valid = 1'b1;
            elem_first = (i == 0);
            act_code   = ba[i];
            wgt_code   = bw[i];
            blk_scale  = (i == 0) ? bs : ~bs;
            tns_scale  = (i == 0) ? ts : ~ts;
            s += prod_q(ba[i], bw[i]);
            if (gaps && (i % 5 == 2)) begin
                @(negedge clk);
                elem_valid = 1'b0;
                elem_first = 1'b0;
                act_code   = 4'h7;
                wgt_code   = 4'h7;
            end
        end
        @(negedge clk);
        elem_valid = 1'b0;
        elem_first = 1'b0;
        check({tag, " R4 done pulse"}, done, 1);
        check({tag, " R7 dot_mant"}, dot_mant, exp_mant(s, bs));
        check({tag, " R7 dot_exp"}, dot_exp, exp_exp(bs));
        check({tag, " R8 tns_out"}, tns_out, ts);
        @(negedge clk);
        check({tag, " R9 done low after pulse"}, done, 0);
        check({tag, " R9 dot_mant held"}, dot_mant, exp_mant(s, bs));
    endtask

    initial begin
        logic signed [MANT_W-1:0] held;

        // Reset state (R9)
        repeat (3) @(negedge clk);
        check("R9 reset done", done, 0);
        check("R9 reset dot_mant", dot_mant, 0);
        check("R9 reset dot_exp", dot_exp, 0);
        check("R9 reset tns_out", tns_out, 0);
        rst_n = 1'b1;

        // Exhaustive operand pairs, unit scale 0x38 (R1, R2, R3)
        for (int a = 0; a < 16; a++) begin
            for (int i = 0; i < BLOCK; i++) begin
                ba[i] = 4'(a);
                bw[i] = 4'(i);
            end
            run_block("R1 R2 pairs", 8'h38, 32'(a * 77 + 5), 1'b0);
        end

        // Zero operands with both signs give zero (R1)
        for (int i = 0; i < BLOCK; i++) begin
            ba[i] = (i % 2) ? 4'h8 : 4'h0;
            bw[i] = 4'hF;
        end
        run_block("R1 zero", 8'h38, 32'h0, 1'b0);

        // Every scale byte on a mixed block (R7, R8)
        for (int k = 0; k < BLOCK; k++) begin
            ba[k] = 4'((k * 7 + 3) % 16);
            bw[k] = 4'((k * 11 + 1) % 16);
        end
        for (int sc = 0; sc < 256; sc++) begin
            run_block("R7 scale sweep", 8'(sc), 32'hA5A50000 + 32'(sc), 1'b0);
        end

        // Largest magnitudes with both signs (R3)
        for (int i = 0; i < BLOCK; i++) begin ba[i] = 4'h7; bw[i] = 4'h7; end
        run_block("R3 max pos", 8'h7F, 32'h1, 1'b0);
        for (int i = 0; i < BLOCK; i++) begin ba[i] = 4'hF; bw[i] = 4'h7; end
        run_block("R3 max neg", 8'h7F, 32'h2, 1'b0);
        run_block("R3 max neg sgn", 8'hFF, 32'h3, 1'b0);

        // Gaps inside a block (R4)
        for (int i = 0; i < BLOCK; i++) begin
            ba[i] = 4'(i);
            bw[i] = 4'(15 - i);
        end
        run_block("R4 gaps", 8'h45, 32'hCAFE0001, 1'b1);

        // Stray elements while idle are ignored (R5)
        held = dot_mant;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (i > 0) check("R5 stray no done", done, 0);
            elem_valid = 1'b1;
            elem_first = 1'b0;
            act_code   = 4'h7;
            wgt_code   = 4'h6;
        end
        @(negedge clk);
        elem_valid = 1'b0;
        check("R5 stray no done", done, 0);
        check("R5 stray outputs held", dot_mant, held);
        run_block("R5 after stray", 8'h30, 32'h5, 1'b0);

        // Restart mid-block discards partial work (R6)
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            elem_valid = 1'b1;
            elem_first = (i == 0);
            act_code   = 4'h7;
            wgt_code   = 4'h7;
            blk_scale  = 8'h77;
            tns_scale  = 32'hDEAD;
        end
        for (int i = 0; i < BLOCK; i++) begin
            ba[i] = 4'(i ^ 5);
            bw[i] = 4'(i ^ 9);
        end
        run_block("R6 restart", 8'hB9, 32'h600D, 1'b0);

        // Pseudo-random blocks (R2, R3, R7)
        for (int n = 0; n < 200; n++) begin
            for (int i = 0; i < BLOCK; i++) begin
                ba[i] = 4'($urandom);
                bw[i] = 4'($urandom);
            end
            run_block("R2 random", 8'($urandom), $urandom, n % 3 == 0);
        end

        summary();
        $finish;
    end

endmodule